// File: doc/BRIEF.md
# CPU Register Bank with Dedicated Low Entries

This block is the register storage of a small 16-bit processor. It holds sixteen 16-bit entries. Entry 0 is the program counter, entry 1 the stack pointer, entry 2 the status word, and entry 3 is a constant source with no storage behind it. Entries 4 to 15 are plain working registers. Software-visible state is changed through one write port. Several dedicated update paths also change it: a program-counter advance, stack push/pop adjustments and a status flag merge.

Two combinational read ports are provided. Port A is the source-operand port. When it selects entry 2 or 3, it also takes the 2-bit source addressing-mode code, and for certain codes it returns a small constant instead of stored data. No memory fetch is needed for those constants. Port B is a plain register read.

A built-in sequencer handles interrupt entry and interrupt return. On entry it saves the program counter and then the status word below the stack pointer, over a word-wide memory port. On return it restores both in the opposite order. Each sequence takes two memory cycles and ends with a one-cycle done strobe.

Top module: `cpu_regbank`

## Requirements
- R1: After reset, every entry reads 0 on port B, and `mem_req` and `seq_done` are low.
- R2: A write with `wr_en` to entries 4..15 is visible on both read ports from the next cycle. For those entries, port A ignores `rd_a_mode`.
- R3: When `pc_step_words` is nonzero (1, 2 or 3), the program counter advances by twice that value (2, 4 or 6 bytes) at the next edge. A value of 0 leaves it unchanged. A same-cycle write to entry 0 takes precedence over the advance.
- R4: Every value that lands in the program counter or the stack pointer has bit 0 forced to 0.
- R5: `sp_push` lowers the stack pointer by 2 and `sp_pop` raises it by 2. When both are asserted, push wins. A same-cycle write to entry 1 wins over both.
- R6: `flag_en` replaces the status bits selected by `flag_mask` with the matching bits of `flag_val`. A same-cycle write to entry 2 wins over the merge.
- R7: Port A with entry 3 returns 0x0000, 0x0001, 0x0002 or 0xFFFF for mode 00, 01, 10 or 11 respectively.
- R8: Port A with entry 2 returns the status word for mode 00, 0x0000 for mode 01, 0x0004 for mode 10 and 0x0008 for mode 11.
- R9: Writes to entry 3 are dropped. Entry 3 reads 0x0000 on port B and on port A in mode 00.
- R10: An interrupt entry is accepted while the sequencer is idle. In the first cycle after acceptance, the block writes the program counter to address SP-2. In the second cycle it writes the status word to SP-4. At the following edge, SP becomes SP-4, the program counter loads `irq_vec` with bit 0 cleared, and `seq_done` is high for one cycle.
- R11: An interrupt return is accepted while the sequencer is idle. In the first cycle after acceptance, the block reads the status word from address SP. In the second cycle it reads the program counter from SP+2. At the following edge, SP becomes SP+4 and `seq_done` is high for one cycle.
- R12: While a sequence runs, port writes, PC advance, push/pop, flag merge and new requests are ignored. If entry and return are requested together, entry is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 4 | Source port entry select |
| rd_a_mode | input | 2 | Source addressing-mode code |
| rd_a_data | output | 16 | Source port data or constant |
| rd_b_idx | input | 4 | Plain read entry select |
| rd_b_data | output | 16 | Plain read data |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Write entry select |
| wr_data | input | 16 | Write data |
| pc_step_words | input | 2 | Instruction length in words, 0 = no advance |
| sp_push | input | 1 | Lower stack pointer by 2 |
| sp_pop | input | 1 | Raise stack pointer by 2 |
| flag_en | input | 1 | Status flag merge strobe |
| flag_mask | input | 16 | Status bits to replace |
| flag_val | input | 16 | New status bit values |
| irq_req | input | 1 | Interrupt entry request |
| irq_vec | input | 16 | Handler address for entry |
| reti_req | input | 1 | Interrupt return request |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, same cycle |
| seq_done | output | 1 | Sequence finished pulse |

## Verification
Port reads and constants are combinational, so the checks sample them in the same cycle, a short settle time after the select changes. Writes, PC advance, stack adjustment and flag merge land at the next rising edge, and each is checked at the falling edge that follows. For a sequence, the first memory access is due one edge after the request and the second access one edge later. The restored registers and `seq_done` are due at the third edge. The bench checks each of these at the falling edge after the relevant edge, and confirms that `seq_done` has dropped again one cycle later.

// File: rtl/cpu_regbank_pkg.sv
package cpu_regbank_pkg;
  localparam int unsigned IDX_PC = 0;
  localparam int unsigned IDX_SP = 1;
  localparam int unsigned IDX_SR = 2;
  localparam int unsigned IDX_CG = 3;
  localparam int unsigned FIRST_GPR = 4;

  typedef enum logic [2:0] {
    SEQ_IDLE   = 3'd0,
    SEQ_ENT_PC = 3'd1,
    SEQ_ENT_SR = 3'd2,
    SEQ_RET_SR = 3'd3,
    SEQ_RET_PC = 3'd4
  } seq_state_e;
endpackage

// File: rtl/rb_gpr_store.sv
module rb_gpr_store #(
  parameter int unsigned DW    = 16,
  parameter int unsigned NREG  = 16,
  parameter int unsigned FIRST = 4,
  localparam int unsigned IW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_a_idx,
  input  logic [IW-1:0] rd_b_idx,
  output logic [DW-1:0] rd_a_val,
  output logic [DW-1:0] rd_b_val
);
  logic [DW-1:0] gpr_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    if (g < FIRST) begin : g_dedicated
      assign gpr_q[g] = '0;
    end else begin : g_store
      logic ent_en;
      assign ent_en = we && (wr_idx == IW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gpr_q[g] <= '0;
        else if (ent_en) gpr_q[g] <= wr_data;
      end
    end
  end

  assign rd_a_val = gpr_q[rd_a_idx];
  assign rd_b_val = gpr_q[rd_b_idx];
endmodule

// File: rtl/rb_const_gen.sv
module rb_const_gen
  import cpu_regbank_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 16,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  logic [IW-1:0] idx,
  input  logic [1:0]    mode,
  input  logic [DW-1:0] reg_val,
  output logic [DW-1:0] src_val
);
  always_comb begin
    src_val = reg_val;
    if (idx == IW'(IDX_CG)) begin
      case (mode)
        2'b00:   src_val = '0;
        2'b01:   src_val = DW'(1);
        2'b10:   src_val = DW'(2);
        default: src_val = '1;
      endcase
    end else if (idx == IW'(IDX_SR)) begin
      case (mode)
        2'b00:   src_val = reg_val;
        2'b01:   src_val = '0;
        2'b10:   src_val = DW'(4);
        default: src_val = DW'(8);
      endcase
    end
  end
endmodule

// File: rtl/rb_irq_seq.sv
module rb_irq_seq
  import cpu_regbank_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_req,
  input  logic          reti_req,
  input  logic [DW-1:0] irq_vec,
  input  logic [DW-1:0] pc_q,
  input  logic [DW-1:0] sp_q,
  input  logic [DW-1:0] sr_q,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          first,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          done,
  output logic          pc_ld,
  output logic [DW-1:0] pc_ld_val,
  output logic          sp_ld,
  output logic [DW-1:0] sp_ld_val,
  output logic          sr_ld,
  output logic [DW-1:0] sr_ld_val
);
  localparam logic [DW-1:0] WSTEP = DW'(2);
  localparam logic [DW-1:0] FRAME = DW'(4);

  seq_state_e    state_q, state_d;
  logic [DW-1:0] vec_q;
  logic          vec_en;
  logic          done_d, done_q;

  assign vec_en = (state_q == SEQ_IDLE) && irq_req;

  always_comb begin
    state_d = state_q;
    case (state_q)
      SEQ_IDLE: begin
        if (irq_req)       state_d = SEQ_ENT_PC;
        else if (reti_req) state_d = SEQ_RET_SR;
      end
      SEQ_ENT_PC: state_d = SEQ_ENT_SR;
      SEQ_RET_SR: state_d = SEQ_RET_PC;
      default:    state_d = SEQ_IDLE;
    endcase
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    pc_ld     = 1'b0;
    pc_ld_val = '0;
    sp_ld     = 1'b0;
    sp_ld_val = '0;
    sr_ld     = 1'b0;
    sr_ld_val = '0;
    case (state_q)
      SEQ_ENT_PC: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sp_q - WSTEP;
        mem_wdata = pc_q;
      end
      SEQ_ENT_SR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sp_q - FRAME;
        mem_wdata = sr_q;
        sp_ld     = 1'b1;
        sp_ld_val = sp_q - FRAME;
        pc_ld     = 1'b1;
        pc_ld_val = vec_q;
      end
      SEQ_RET_SR: begin
        mem_req   = 1'b1;
        mem_addr  = sp_q;
        sr_ld     = 1'b1;
        sr_ld_val = mem_rdata;
      end
      SEQ_RET_PC: begin
        mem_req   = 1'b1;
        mem_addr  = sp_q + WSTEP;
        pc_ld     = 1'b1;
        pc_ld_val = mem_rdata;
        sp_ld     = 1'b1;
        sp_ld_val = sp_q + FRAME;
      end
      default: ;
    endcase
  end

  assign done_d = (state_q == SEQ_ENT_SR) || (state_q == SEQ_RET_PC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec_q <= '0;
    else if (vec_en) vec_q <= irq_vec;
  end

  assign busy  = (state_q != SEQ_IDLE);
  assign first = (state_q == SEQ_ENT_PC) || (state_q == SEQ_RET_SR);
  assign done  = done_q;
endmodule

// File: rtl/cpu_regbank.sv
module cpu_regbank
  import cpu_regbank_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 16,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_a_idx,
  input  logic [1:0]    rd_a_mode,
  output logic [DW-1:0] rd_a_data,
  input  logic [IW-1:0] rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    pc_step_words,
  input  logic          sp_push,
  input  logic          sp_pop,
  input  logic          flag_en,
  input  logic [DW-1:0] flag_mask,
  input  logic [DW-1:0] flag_val,
  input  logic          irq_req,
  input  logic [DW-1:0] irq_vec,
  input  logic          reti_req,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          seq_done
);
  localparam logic [DW-1:0] ALIGN = {{(DW-1){1'b1}}, 1'b0};
  localparam logic [DW-1:0] SP_STEP = DW'(2);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  logic [DW-1:0] pc_q, pc_d, sp_q, sp_d, sr_q, sr_d;
  logic          pc_en, sp_en, sr_en;
  logic          seq_busy, seq_first;
  logic          pc_ld, sp_ld, sr_ld;
  logic [DW-1:0] pc_ld_val, sp_ld_val, sr_ld_val;
  logic          port_ok, wr_pc, wr_sp, wr_sr, gpr_we;
  logic [DW-1:0] gpr_a, gpr_b, raw_a, raw_b;

  rb_irq_seq #(.DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .irq_req   (irq_req),
    .reti_req  (reti_req),
    .irq_vec   (irq_vec),
    .pc_q      (pc_q),
    .sp_q      (sp_q),
    .sr_q      (sr_q),
    .mem_rdata (mem_rdata),
    .busy      (seq_busy),
    .first     (seq_first),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .done      (seq_done),
    .pc_ld     (pc_ld),
    .pc_ld_val (pc_ld_val),
    .sp_ld     (sp_ld),
    .sp_ld_val (sp_ld_val),
    .sr_ld     (sr_ld),
    .sr_ld_val (sr_ld_val)
  );

  assign port_ok = !seq_busy;
  assign wr_pc   = port_ok && wr_en && (wr_idx == IW'(IDX_PC));
  assign wr_sp   = port_ok && wr_en && (wr_idx == IW'(IDX_SP));
  assign wr_sr   = port_ok && wr_en && (wr_idx == IW'(IDX_SR));
  assign gpr_we  = port_ok && wr_en;

  // clock enables
  assign pc_en = pc_ld || wr_pc || (port_ok && (pc_step_words != 2'd0));
  assign sp_en = sp_ld || wr_sp || (port_ok && (sp_push || sp_pop));
  assign sr_en = sr_ld || wr_sr || (port_ok && flag_en);

  // next state
  always_comb begin
    if (pc_ld)      pc_d = pc_ld_val;
    else if (wr_pc) pc_d = wr_data;
    else            pc_d = pc_q + DW'({pc_step_words, 1'b0});
    pc_d = pc_d & ALIGN;

    if (sp_ld)        sp_d = sp_ld_val;
    else if (wr_sp)   sp_d = wr_data;
    else if (sp_push) sp_d = sp_q - SP_STEP;
    else              sp_d = sp_q + SP_STEP;
    sp_d = sp_d & ALIGN;

    if (sr_ld)      sr_d = sr_ld_val;
    else if (wr_sr) sr_d = wr_data;
    else            sr_d = (sr_q & ~flag_mask) | (flag_val & flag_mask);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      pc_q <= '0;
      sp_q <= '0;
      sr_q <= '0;
    end else begin
      if (pc_en) pc_q <= pc_d;
      if (sp_en) sp_q <= sp_d;
      if (sr_en) sr_q <= sr_d;
    end
  end

  rb_gpr_store #(.DW(DW), .NREG(NREG), .FIRST(FIRST_GPR)) u_gpr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .we       (gpr_we),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rd_a_idx (rd_a_idx),
    .rd_b_idx (rd_b_idx),
    .rd_a_val (gpr_a),
    .rd_b_val (gpr_b)
  );

  function automatic logic [DW-1:0] pick(input logic [IW-1:0] i,
                                         input logic [DW-1:0] pc,
                                         input logic [DW-1:0] sp,
                                         input logic [DW-1:0] sr,
                                         input logic [DW-1:0] gpr);
    if (i == IW'(IDX_PC))      return pc;
    else if (i == IW'(IDX_SP)) return sp;
    else if (i == IW'(IDX_SR)) return sr;
    else if (i == IW'(IDX_CG)) return '0;
    else                       return gpr;
  endfunction

  assign raw_a     = pick(rd_a_idx, pc_q, sp_q, sr_q, gpr_a);
  assign raw_b     = pick(rd_b_idx, pc_q, sp_q, sr_q, gpr_b);
  assign rd_b_data = raw_b;

  rb_const_gen #(.DW(DW), .NREG(NREG)) u_cg (
    .idx     (rd_a_idx),
    .mode    (rd_a_mode),
    .reg_val (raw_a),
    .src_val (rd_a_data)
  );
endmodule

// File: rtl/cpu_regbank_chk.sv
module cpu_regbank_chk #(
  parameter int unsigned DW = 16,
  parameter int unsigned IW = 4
) (
  input logic          clk,
  input logic          rst_ok,
  input logic [DW-1:0] pc_q,
  input logic [DW-1:0] sp_q,
  input logic          seq_busy,
  input logic          seq_first,
  input logic          wr_en,
  input logic [IW-1:0] wr_idx,
  input logic [1:0]    pc_step_words,
  input logic          sp_push,
  input logic          sp_pop,
  input logic          irq_req,
  input logic          mem_req,
  input logic          mem_we,
  input logic [DW-1:0] mem_addr,
  input logic          seq_done,
  input logic [IW-1:0] rd_b_idx,
  input logic [DW-1:0] rd_b_data
);
  // R4
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !pc_q[0] && !sp_q[0]);

  // R3
  pc_advance_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!seq_busy && pc_step_words != 2'd0 && !(wr_en && wr_idx == IW'(0)))
    |=> pc_q == $past(pc_q) + DW'({$past(pc_step_words), 1'b0}));

  // R10
  entry_first_write_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!seq_busy && irq_req && !sp_push && !sp_pop && !(wr_en && wr_idx == IW'(1)))
    |=> mem_req && mem_we && mem_addr == $past(sp_q) - DW'(2));

  // R11
  done_after_access_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    seq_done |-> !seq_busy && !mem_req && $past(mem_req));

  // R12
  first_cycle_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    seq_first |=> $stable(pc_q) && $stable(sp_q));

  // R9
  cg_plain_zero_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (rd_b_idx == IW'(3)) |-> rd_b_data == '0);
endmodule

bind cpu_regbank cpu_regbank_chk #(.DW(DW), .IW(IW)) u_chk (
  .clk           (clk),
  .rst_ok        (rst_n_s),
  .pc_q          (pc_q),
  .sp_q          (sp_q),
  .seq_busy      (seq_busy),
  .seq_first     (seq_first),
  .wr_en         (wr_en),
  .wr_idx        (wr_idx),
  .pc_step_words (pc_step_words),
  .sp_push       (sp_push),
  .sp_pop        (sp_pop),
  .irq_req       (irq_req),
  .mem_req       (mem_req),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr),
  .seq_done      (seq_done),
  .rd_b_idx      (rd_b_idx),
  .rd_b_data     (rd_b_data)
);

// File: tb/cpu_regbank_tb.sv
`timescale 1ns/1ps
module cpu_regbank_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [1:0]  rd_a_mode, pc_step_words;
  logic [15:0] rd_a_data, rd_b_data, wr_data, flag_mask, flag_val, irq_vec;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        wr_en, sp_push, sp_pop, flag_en, irq_req, reti_req;
  logic        mem_req, mem_we, seq_done;
  logic [15:0] mem [64];
  int          n_tests = 0;
  int          n_fail  = 0;

  always #4 clk = ~clk;

  cpu_regbank u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_mode(rd_a_mode), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pc_step_words(pc_step_words), .sp_push(sp_push), .sp_pop(sp_pop),
    .flag_en(flag_en), .flag_mask(flag_mask), .flag_val(flag_val),
    .irq_req(irq_req), .irq_vec(irq_vec), .reti_req(reti_req),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .seq_done(seq_done)
  );

  assign mem_rdata = mem[mem_addr[6:1]];
  always @(posedge clk) if (mem_req && mem_we) mem[mem_addr[6:1]] <= mem_wdata;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic quiet();
    wr_en = 0; wr_idx = 0; wr_data = 0; pc_step_words = 0;
    sp_push = 0; sp_pop = 0; flag_en = 0; flag_mask = 0; flag_val = 0;
    irq_req = 0; irq_vec = 0; reti_req = 0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rdb(input logic [3:0] i, output logic [15:0] v);
    rd_b_idx = i; #1; v = rd_b_data;
  endtask

  task automatic rda(input logic [3:0] i, input logic [1:0] m, output logic [15:0] v);
    rd_a_idx = i; rd_a_mode = m; #1; v = rd_a_data;
  endtask

  task automatic put(input logic [3:0] i, input logic [15:0] d);
    quiet(); wr_en = 1; wr_idx = i; wr_data = d; tick(); quiet();
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int i = 0; i < 16; i++) begin
      rdb(4'(i), v); chk("R1 entry after reset", v, 16'h0);
    end
    chk("R1 mem_req after reset", {15'h0, mem_req}, 16'h0);
    chk("R1 seq_done after reset", {15'h0, seq_done}, 16'h0);
  endtask

  task automatic t_gpr();
    logic [15:0] v;
    put(4'd4, 16'hA5A5);
    put(4'd15, 16'h1234);
    rdb(4'd4, v);          chk("R2 port B entry 4", v, 16'hA5A5);
    rda(4'd15, 2'b10, v);  chk("R2 port A entry 15 mode ignored", v, 16'h1234);
    rda(4'd4, 2'b11, v);   chk("R2 port A entry 4 mode ignored", v, 16'hA5A5);
  endtask

  task automatic t_pc();
    logic [15:0] v;
    put(4'd0, 16'h0100);
    pc_step_words = 2'd1; tick(); quiet();
    rdb(4'd0, v); chk("R3 step 1 word", v, 16'h0102);
    pc_step_words = 2'd3; tick(); quiet();
    rdb(4'd0, v); chk("R3 step 3 words", v, 16'h0108);
    pc_step_words = 2'd2; tick(); quiet();
    rdb(4'd0, v); chk("R3 step 2 words", v, 16'h010C);
    tick();
    rdb(4'd0, v); chk("R3 step 0 holds", v, 16'h010C);
    wr_en = 1; wr_idx = 0; wr_data = 16'h0200; pc_step_words = 2'd3; tick(); quiet();
    rdb(4'd0, v); chk("R3 write beats step", v, 16'h0200);
  endtask

  task automatic t_align();
    logic [15:0] v;
    put(4'd0, 16'h0301);
    rdb(4'd0, v); chk("R4 pc bit0 cleared", v, 16'h0300);
    put(4'd1, 16'h0455);
    rdb(4'd1, v); chk("R4 sp bit0 cleared", v, 16'h0454);
  endtask

  task automatic t_stack();
    logic [15:0] v;
    put(4'd1, 16'h0080);
    sp_push = 1; tick(); quiet();
    rdb(4'd1, v); chk("R5 push", v, 16'h007E);
    sp_pop = 1; tick(); quiet();
    rdb(4'd1, v); chk("R5 pop", v, 16'h0080);
    sp_push = 1; sp_pop = 1; tick(); quiet();
    rdb(4'd1, v); chk("R5 push beats pop", v, 16'h007E);
    wr_en = 1; wr_idx = 1; wr_data = 16'h0060; sp_push = 1; tick(); quiet();
    rdb(4'd1, v); chk("R5 write beats push", v, 16'h0060);
  endtask

  task automatic t_flags();
    logic [15:0] v;
    put(4'd2, 16'h00F0);
    flag_en = 1; flag_mask = 16'h000F; flag_val = 16'hFFF5; tick(); quiet();
    rdb(4'd2, v); chk("R6 masked merge", v, 16'h00F5);
    wr_en = 1; wr_idx = 2; wr_data = 16'h1111; flag_en = 1; flag_mask = 16'hFFFF; tick(); quiet();
    rdb(4'd2, v); chk("R6 write beats merge", v, 16'h1111);
  endtask

  task automatic t_const();
    logic [15:0] v;
    rda(4'd3, 2'b00, v); chk("R7 cg3 mode00", v, 16'h0000);
    rda(4'd3, 2'b01, v); chk("R7 cg3 mode01", v, 16'h0001);
    rda(4'd3, 2'b10, v); chk("R7 cg3 mode10", v, 16'h0002);
    rda(4'd3, 2'b11, v); chk("R7 cg3 mode11", v, 16'hFFFF);
    rda(4'd2, 2'b00, v); chk("R8 sr mode00", v, 16'h1111);
    rda(4'd2, 2'b01, v); chk("R8 sr mode01", v, 16'h0000);
    rda(4'd2, 2'b10, v); chk("R8 sr mode10", v, 16'h0004);
    rda(4'd2, 2'b11, v); chk("R8 sr mode11", v, 16'h0008);
  endtask

  task automatic t_cg_write();
    logic [15:0] v;
    put(4'd3, 16'hBEEF);
    rdb(4'd3, v);        chk("R9 entry 3 port B", v, 16'h0000);
    rda(4'd3, 2'b00, v); chk("R9 entry 3 port A", v, 16'h0000);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    put(4'd1, 16'h0080);
    put(4'd0, 16'h1234);
    put(4'd2, 16'h0105);
    irq_req = 1; reti_req = 1; irq_vec = 16'hC001; tick(); quiet();
    chk("R10 first access req", {14'h0, mem_req, mem_we}, 16'h0003);
    chk("R12 entry taken over return, addr", mem_addr, 16'h007E);
    chk("R10 first access data", mem_wdata, 16'h1234);
    wr_en = 1; wr_idx = 4; wr_data = 16'hDEAD; pc_step_words = 2'd1; sp_push = 1;
    irq_vec = 16'h0000;
    tick(); quiet();
    chk("R10 second access req", {14'h0, mem_req, mem_we}, 16'h0003);
    chk("R10 second access addr", mem_addr, 16'h007C);
    chk("R10 second access data", mem_wdata, 16'h0105);
    tick();
    chk("R10 done pulse", {15'h0, seq_done}, 16'h0001);
    chk("R10 memory idle", {15'h0, mem_req}, 16'h0000);
    rdb(4'd1, v); chk("R10 sp lowered", v, 16'h007C);
    rdb(4'd0, v); chk("R10 pc from vector", v, 16'hC000);
    chk("R10 stacked pc", mem[6'h3F], 16'h1234);
    chk("R10 stacked sr", mem[6'h3E], 16'h0105);
    rdb(4'd4, v); chk("R12 write ignored while busy", v, 16'hA5A5);
    tick();
    chk("R10 done one cycle", {15'h0, seq_done}, 16'h0000);
  endtask

  task automatic t_reti();
    logic [15:0] v;
    mem[6'h3E] = 16'h00FF;
    mem[6'h3F] = 16'h2223;
    reti_req = 1; tick(); quiet();
    chk("R11 first access read", {14'h0, mem_req, mem_we}, 16'h0002);
    chk("R11 first access addr", mem_addr, 16'h007C);
    tick();
    chk("R11 second access addr", mem_addr, 16'h007E);
    rdb(4'd2, v); chk("R11 sr restored first", v, 16'h00FF);
    tick();
    chk("R11 done pulse", {15'h0, seq_done}, 16'h0001);
    rdb(4'd0, v); chk("R11 pc restored aligned", v, 16'h2222);
    rdb(4'd1, v); chk("R11 sp raised", v, 16'h0080);
    tick();
    chk("R11 done one cycle", {15'h0, seq_done}, 16'h0000);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'h0;
    quiet();
    rd_a_idx = 0; rd_a_mode = 0; rd_b_idx = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_gpr();
    t_pc();
    t_align();
    t_stack();
    t_flags();
    t_const();
    t_cg_write();
    t_irq();
    t_reti();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule